// File: doc/BRIEF.md
# Linked-Load / Conditional-Store Reservation Monitor

This block holds a single address reservation for one processor request port. It lets software build atomic read-modify-write sequences out of a linked load and a conditional store. It contains a small word-addressed memory. Every request to that memory passes through the block. A second write port carries stores from another agent, and the block watches it as a snoop.

A linked load returns a word and reserves that word's address. The reservation is lost when any write reaches the reserved word. Such a write can come from the snoop port or from an ordinary local store. A conditional store commits only while its reservation is still intact. It never stalls. Instead it reports its outcome as result 1 (committed) or 0 (refused), and software retries the sequence on 0. Every request gets exactly one response, one clock after it is accepted.

Top module: `resv_monitor`

## Requirements
- R1: A request with `req_op` 00 (load) gives `rsp_valid`=1 one cycle later, with `rsp_data` set to the stored word. A cycle with no request gives `rsp_valid`=0 in the next cycle.
- R2: A request with `req_op` 10 (linked load) returns the stored word, like a load, and reserves `req_addr`.
- R3: A conditional store (`req_op` 11) to the reserved address, with no intervening write to it, writes `req_wdata` and returns `rsp_data`=1. It also drops the reservation, so a following conditional store returns 0.
- R4: A conditional store with no reservation, or to an address other than the reserved one, returns 0 and leaves memory unchanged. A conditional-store result always has every bit above bit 0 at zero.
- R5: A snoop write (`snp_we`=1) updates memory in the cycle it is presented. If it targets the reserved address, it drops the reservation.
- R6: An ordinary store (`req_op` 01) to the reserved address drops the reservation.
- R7: A new linked load replaces any earlier reservation.
- R8: Reset drops the reservation and holds `rsp_valid` at 0.
- R9: If a conditional store and a snoop write target the same address in the same cycle, the snoop data lands in memory and the conditional store returns 0.
- R10: Writes to other addresses, from either port, leave the reservation intact.
- R11: An ordinary store returns `rsp_data`=0.
- R12: A linked load that meets a snoop write to the same address in the same cycle returns the old word and leaves no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | 00 load, 01 store, 10 linked load, 11 conditional store |
| req_addr | input | AW | Word address of the local request |
| req_wdata | input | DW | Store data |
| snp_we | input | 1 | Write from the other agent |
| snp_addr | input | AW | Word address of the snoop write |
| snp_wdata | input | DW | Snoop write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_data | output | DW | Read word, conditional-store result, or 0 |

## Verification
A reservation that is wrongly kept or wrongly dropped is not visible at the ports until the next conditional store. It then shows as a wrong 0/1 result, one cycle after that store is issued. A store that commits when it should not, or is lost, shows up one cycle after the next load of that word. For this reason, the vector walk follows each conditional store with a load of the same address. Same-cycle collisions between the snoop port and the local port are placed in consecutive vectors, so each ordering is observed immediately.

// File: rtl/resv_monitor.sv
`timescale 1ns/1ps
module resv_monitor #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          snp_we,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam logic [1:0] OP_LD = 2'b00, OP_ST = 2'b01, OP_LL = 2'b10, OP_SC = 2'b11;

  logic [DW-1:0] mem [DEPTH];
  logic          rsv_vld;
  logic [AW-1:0] rsv_addr;
  logic [DW-1:0] rsp_nxt;

  wire is_st   = req_valid && req_op == OP_ST;
  wire is_ll   = req_valid && req_op == OP_LL;
  wire is_sc   = req_valid && req_op == OP_SC;
  wire snp_hit = snp_we && snp_addr == req_addr;
  wire sc_ok   = is_sc && rsv_vld && rsv_addr == req_addr && !snp_hit;
  wire loc_we  = (is_st || sc_ok) && !snp_hit;
  wire kill    = (snp_we && snp_addr == rsv_addr) || (is_st && req_addr == rsv_addr);

  always_ff @(posedge clk) begin
    if (loc_we) mem[req_addr] <= req_wdata;
    if (snp_we) mem[snp_addr] <= snp_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv_vld  <= 1'b0;
      rsv_addr <= '0;
    end else if (is_ll) begin
      rsv_vld  <= !snp_hit;
      rsv_addr <= req_addr;
    end else if (is_sc || kill) begin
      rsv_vld  <= 1'b0;
    end
  end

  always_comb begin
    unique case (req_op)
      OP_LD, OP_LL: rsp_nxt = mem[req_addr];
      OP_SC:        rsp_nxt = {{(DW-1){1'b0}}, sc_ok};
      default:      rsp_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_data  <= req_valid ? rsp_nxt : '0;
    end
  end
endmodule

module resv_monitor_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic          snp_we,
  input logic [AW-1:0] snp_addr,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_SC_RESULT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |=> rsp_data[DW-1:1] == '0); // R4
  AST_SC_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) ##1 (req_valid && req_op == 2'b11) |=> rsp_data == '0); // R3
  AST_SC_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11 && $past(snp_we) && $past(snp_addr) == req_addr) |=> rsp_data == '0); // R5
  AST_SC_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11 && $past(req_valid) && $past(req_op) == 2'b01 &&
     $past(req_addr) == req_addr) |=> rsp_data == '0); // R6
  AST_SC_SNOOP_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11 && snp_we && snp_addr == req_addr) |=> rsp_data == '0); // R9
  AST_STORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01) |=> rsp_data == '0); // R11
endmodule

bind resv_monitor resv_monitor_chk #(.DW(DW), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/resv_monitor_tb.sv
`timescale 1ns/1ps
module resv_monitor_tb_top;
  localparam int DW = 32, DEPTH = 16, AW = 4;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  typedef struct packed {
    logic          v;
    logic [1:0]    op;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          sw;
    logic [AW-1:0] sa;
    logic [DW-1:0] sd;
    logic [DW-1:0] exp;
    logic [7:0]    rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{1, ST, 1, 32'h11,  0, 0, 0,       32'h0,   11}, // R11
    '{1, ST, 2, 32'h22,  0, 0, 0,       32'h0,   11}, // R11
    '{1, LD, 1, 0,       0, 0, 0,       32'h11,  1 }, // R1
    '{1, LL, 1, 0,       0, 0, 0,       32'h11,  2 }, // R2
    '{1, SC, 1, 32'h111, 0, 0, 0,       32'h1,   3 }, // R3 commit
    '{1, LD, 1, 0,       0, 0, 0,       32'h111, 3 }, // R3 data written
    '{1, SC, 1, 32'h999, 0, 0, 0,       32'h0,   3 }, // R3 reservation gone
    '{1, LD, 1, 0,       0, 0, 0,       32'h111, 4 }, // R4 no write
    '{1, LL, 2, 0,       0, 0, 0,       32'h22,  7 }, // R7
    '{1, LL, 1, 0,       0, 0, 0,       32'h111, 7 }, // R7 replaces
    '{1, SC, 2, 32'h5,   0, 0, 0,       32'h0,   4 }, // R4 other address
    '{1, LD, 2, 0,       0, 0, 0,       32'h22,  4 }, // R4
    '{1, LL, 1, 0,       0, 0, 0,       32'h111, 2 }, // R2
    '{0, LD, 0, 0,       1, 1, 32'h777, 32'h0,   1 }, // R1 idle, snoop
    '{1, SC, 1, 32'h6,   0, 0, 0,       32'h0,   5 }, // R5
    '{1, LD, 1, 0,       0, 0, 0,       32'h777, 5 }, // R5 snoop landed
    '{1, LL, 2, 0,       0, 0, 0,       32'h22,  2 }, // R2
    '{1, LD, 1, 0,       1, 3, 32'h33,  32'h777, 10}, // R10 snoop elsewhere
    '{1, ST, 4, 32'h44,  0, 0, 0,       32'h0,   10}, // R10 store elsewhere
    '{1, SC, 2, 32'h23,  0, 0, 0,       32'h1,   10}, // R10 still reserved
    '{1, LL, 2, 0,       0, 0, 0,       32'h23,  2 }, // R2
    '{1, ST, 2, 32'h24,  0, 0, 0,       32'h0,   6 }, // R6
    '{1, SC, 2, 32'h25,  0, 0, 0,       32'h0,   6 }, // R6
    '{1, LD, 2, 0,       0, 0, 0,       32'h24,  6 }, // R6
    '{1, LL, 1, 0,       0, 0, 0,       32'h777, 2 }, // R2
    '{1, SC, 1, 32'h8,   1, 1, 32'h888, 32'h0,   9 }, // R9
    '{1, LD, 1, 0,       0, 0, 0,       32'h888, 9 }, // R9 snoop data kept
    '{1, LL, 3, 0,       1, 3, 32'h34,  32'h33,  12}, // R12 old word
    '{1, SC, 3, 32'h35,  0, 0, 0,       32'h0,   12}, // R12 no reservation
    '{1, LD, 3, 0,       0, 0, 0,       32'h34,  12}  // R12
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, snp_we = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0, snp_addr = 0;
  logic [DW-1:0] req_wdata = 0, snp_wdata = 0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  resv_monitor #(.DW(DW), .DEPTH(DEPTH)) dut_i (.*);

  task automatic check(input bit ok, input int rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step(input vec_t t);
    req_valid = t.v; req_op = t.op; req_addr = t.a; req_wdata = t.d;
    snp_we = t.sw; snp_addr = t.sa; snp_wdata = t.sd;
    @(negedge clk);
    check(rsp_valid == t.v, int'(t.rq), {31'b0, rsp_valid}, {31'b0, t.v});
    if (t.v) check(rsp_data == t.exp, int'(t.rq), rsp_data, t.exp);
  endtask

  task automatic idle();
    req_valid = 0; snp_we = 0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 0, 8, {31'b0, rsp_valid}, 0); // R8 reset state
    rst_n = 1;
    for (int i = 0; i < NV; i++) step(TBL[i]);
    step('{1, LL, 1, 0, 0, 0, 0, 32'h888, 2});
    idle();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid == 0, 8, {31'b0, rsp_valid}, 0); // R8 held low
    rst_n = 1;
    @(negedge clk);
    step('{1, SC, 1, 32'h9, 0, 0, 0, 32'h0, 8});   // R8 reservation dropped
    step('{1, LD, 1, 0, 0, 0, 0, 32'h888, 8});     // R8 memory untouched
    idle();
    @(negedge clk);
    check(rsp_valid == 0, 1, {31'b0, rsp_valid}, 0); // R1 idle
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule